// File: doc/BRIEF.md
# Multi-Channel Audio Serial Receiver

This block takes in audio sample data on up to three serial data lines. The lines are timed by a bit clock and a left/right frame clock. It turns them into six 20-bit channel words, one for each DAC channel. Samples arrive in two's complement, most significant bit first. The first bit after each frame-clock change is the MSB of that half. In slave mode the bit clock and frame clock come from outside. In master mode the block divides its system clock to make both, drives them out, and receives data timed against them. The bit clock count per frame is programmable, and so is the bit-clock edge on which data is sampled. In single-line mode all six channels are packed onto the first data line.

All serial inputs are brought into the system clock domain through a two-stage synchronizer. Every frame-clock change is checked against the programmed half-frame length. A mismatch is treated as loss of synchronization. The block then clears its data path and its outputs. Output resumes only after the data stream has again delivered two consecutive well-formed frames. The six words are published together with a one-cycle strobe.

Top module: `audio_ser_rx`

## Requirements
- R1: While rst_n is low and on the first cycles after it is released, dac_data is all zero, frame_valid and sync_err are 0. In slave mode clk_oe is 0.
- R2: Each channel word is 20 bits, MSB first and left-justified. When a half frame is shorter than 20 bits, the unreceived low bits are zero. Bits beyond the 20th in a half are ignored.
- R3: cfg_ratio selects bit clocks per frame: 2'b00=32, 2'b01=48, 2'b10=64, 2'b11=128. The frame clock is low for the left half and high for the right half. A frame begins where the frame clock falls. Each half holds exactly ratio/2 bits.
- R4: cfg_edge=0 samples data and frame clock on the rising bit-clock edge; cfg_edge=1 samples on the falling edge.
- R5: In multi-line mode (cfg_single=0), line k (k=0..2) carries channel 2k in the left half and channel 2k+1 in the right half. Channel n occupies dac_data[20n+19:20n].
- R6: In single-line mode (cfg_single=1) the frame is 128 bits whatever cfg_ratio holds. Channel n takes frame bits 20n..20n+19, counted from the frame start across both halves. Frame bits 120..127 and data lines 1 and 2 are ignored.
- R7: All six words change in the same cycle, together with a one-cycle frame_valid pulse. This happens when the first bit of the following frame is received. dac_data does not change in any other cycle except on a sync error.
- R8: A half frame that ends early or runs past ratio/2 bits causes a one-cycle sync_err pulse. In that same cycle dac_data is zero and frame_valid is 0.
- R9: After reset or a sync error, the first complete correct frame is not published. frame_valid resumes with the second consecutive correct frame.
- R10: cfg_mode=2'b01 is master mode. clk_oe is 1, bclk_out has a period of 2*CLK_DIV system clocks, and lrck_out toggles only on the non-sampling bit-clock edge, every ratio/2 bits. Any other cfg_mode value is slave mode, with bclk_out and lrck_out held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Clock role: 2'b01 master, others slave |
| cfg_ratio | input | 2 | Bit clocks per frame select |
| cfg_edge | input | 1 | Sampling edge: 0 rising, 1 falling |
| cfg_single | input | 1 | All six channels on data line 0 |
| bclk_in | input | 1 | External bit clock (slave) |
| lrck_in | input | 1 | External frame clock (slave) |
| sdata_in | input | 3 | Serial data lines |
| bclk_out | output | 1 | Generated bit clock (master) |
| lrck_out | output | 1 | Generated frame clock (master) |
| clk_oe | output | 1 | High when the block drives the clocks |
| dac_data | output | 120 | Six channel words, channel n at [20n+19:20n] |
| frame_valid | output | 1 | One-cycle strobe on new channel words |
| sync_err | output | 1 | One-cycle pulse on loss of framing |

## Verification
The assertions check four things on every cycle:
- frame_valid is a single-cycle pulse.
- The channel words move only with that pulse or with a sync error.
- A sync error always coincides with cleared words and no strobe.
- In master mode the generated frame clock only changes on the non-sampling bit-clock edge.

Other behaviour needs the bench's scenarios:
- the bit ordering and packing of each ratio, mode and edge;
- the ignored bits;
- the two-frame relock after short and long halves;
- the generated clock period and half length.

// File: rtl/audio_rx_pkg.sv
// Shared constants and helpers for the multi-channel audio serial receiver.
// Assumes the single-line layout fits a 128-bit frame (six 20-bit slots).
package audio_rx_pkg;

    localparam logic [1:0] MODE_MASTER = 2'b01;
    localparam int unsigned SL_HALF    = 64;   // half length in single-line mode
    localparam int unsigned HALF_W     = 7;    // width of a half-frame length

    // Bits per half frame from ratio select; single-line forces 128 per frame.
    function automatic logic [HALF_W-1:0] half_of(input logic [1:0] ratio,
                                                  input logic       single);
        logic [HALF_W-1:0] h;
        if (single) begin
            h = HALF_W'(SL_HALF);
        end else begin
            case (ratio)
                2'b00:   h = 7'd16;
                2'b01:   h = 7'd24;
                2'b10:   h = 7'd32;
                default: h = 7'd64;
            endcase
        end
        return h;
    endfunction

endpackage

// File: rtl/ars_clkgen.sv
// Master-mode clock generator: divides clk into a bit clock and a frame clock.
// The bit clock toggles every DIV cycles; the frame clock toggles together with
// a non-sampling bit-clock edge once every half_len bits. Held idle when not enabled.
module ars_clkgen #(
    parameter int unsigned DIV    = 3,
    parameter int unsigned HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              edge_sel,
    input  logic [HALF_W-1:0] half_len,
    output logic              bclk_o,
    output logic              lrck_o
);
    localparam int unsigned DW = $clog2(DIV) + 1;

    logic [DW-1:0]     div_cnt;
    logic [HALF_W-1:0] bit_cnt;

    // Divider, bit counter and frame clock toggling.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_cnt <= '0;
            bclk_o  <= edge_sel;
            bit_cnt <= '0;
            lrck_o  <= 1'b1;
        end else if (div_cnt == DW'(DIV - 1)) begin
            div_cnt <= '0;
            bclk_o  <= ~bclk_o;
            if (bclk_o != edge_sel) begin
                if (bit_cnt == half_len - 1'b1) begin
                    bit_cnt <= '0;
                    lrck_o  <= ~lrck_o;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ars_front.sv
// Input front end: selects pin or generated clocks, synchronizes clocks and data
// into clk with two flops, and emits one strobe per sampling bit-clock edge.
// Assumes each bit-clock level lasts at least two clk cycles.
module ars_front #(
    parameter int unsigned NLINE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master,
    input  logic             edge_sel,
    input  logic             bclk_pin,
    input  logic             lrck_pin,
    input  logic [NLINE-1:0] sd_pin,
    input  logic             bclk_gen,
    input  logic             lrck_gen,
    output logic             bit_stb,
    output logic             bit_lr,
    output logic [NLINE-1:0] bit_d
);
    localparam int unsigned SW = NLINE + 2;

    logic [SW-1:0] raw, s1, s2;
    logic          b_prev;

    // Choose the clock source for the current role.
    always_comb begin
        raw = {master ? bclk_gen : bclk_pin, master ? lrck_gen : lrck_pin, sd_pin};
    end

    // Two-stage synchronizer and previous bit-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1     <= '0;
            s2     <= '0;
            b_prev <= 1'b0;
        end else begin
            s1     <= raw;
            s2     <= s1;
            b_prev <= s2[SW-1];
        end
    end

    // Edge select and sampled bit outputs.
    always_comb begin
        bit_stb = edge_sel ? (!s2[SW-1] && b_prev) : (s2[SW-1] && !b_prev);
        bit_lr  = s2[SW-2];
        bit_d   = s2[NLINE-1:0];
    end

endmodule

// File: rtl/ars_framer.sv
// Frame tracker: counts bits per half, checks each half against half_len, flags
// loss of sync and decides when a completed frame may be published (second
// consecutive correct frame onwards). Assumes bit_stb is a single-cycle pulse.
module ars_framer #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_lr,
    input  logic [HALF_W-1:0] half_len,
    output logic              wr_en,
    output logic              wr_right,
    output logic [CNT_W-1:0]  wr_idx,
    output logic              frame_start,
    output logic              publish,
    output logic              dp_clear,
    output logic              sync_err
);
    logic             seen, lr_prev, have_ref, frame_good;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       good_cnt;
    logic             trans, cnt_ok, err_short, err_long, complete;

    // Event decode for the bit arriving this cycle.
    always_comb begin
        trans       = bit_stb && seen && (bit_lr != lr_prev);
        cnt_ok      = (cnt == CNT_W'(half_len));
        err_short   = trans && have_ref && !cnt_ok;
        err_long    = bit_stb && !trans && have_ref && cnt_ok;
        complete    = trans && !bit_lr && have_ref && cnt_ok && frame_good;
        publish     = complete && (good_cnt != 2'd0);
        dp_clear    = err_short || err_long;
        frame_start = trans && !bit_lr;
        wr_en       = bit_stb && !err_long;
        wr_right    = bit_lr;
        wr_idx      = trans ? '0 : cnt;
    end

    // Bit counting, reference and frame tracking state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen       <= 1'b0;
            lr_prev    <= 1'b0;
            have_ref   <= 1'b0;
            frame_good <= 1'b0;
            cnt        <= '0;
        end else if (bit_stb) begin
            seen    <= 1'b1;
            lr_prev <= bit_lr;
            if (trans) begin
                cnt      <= CNT_W'(1);
                have_ref <= 1'b1;
                if (!bit_lr)
                    frame_good <= 1'b1;
                else if (err_short)
                    frame_good <= 1'b0;
            end else if (err_long) begin
                have_ref   <= 1'b0;
                frame_good <= 1'b0;
                cnt        <= (cnt != '1) ? cnt + 1'b1 : cnt;
            end else begin
                cnt <= (cnt != '1) ? cnt + 1'b1 : cnt;
            end
        end
    end

    // Consecutive-good-frame counter and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_cnt <= 2'd0;
            sync_err <= 1'b0;
        end else begin
            sync_err <= dp_clear;
            if (dp_clear)
                good_cnt <= 2'd0;
            else if (complete)
                good_cnt <= (good_cnt == 2'd0) ? 2'd1 : 2'd2;
        end
    end

endmodule

// File: rtl/ars_unpack.sv
// Channel unpacker: steers each received bit into its channel accumulator
// (multi-line pairs or single-line 20-bit slots), and copies all accumulators
// to the outputs on publish. A data-path clear zeroes accumulators and outputs.
module ars_unpack #(
    parameter int unsigned WORD_W = 20,
    parameter int unsigned NLINE  = 3,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned HALF_W = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      single,
    input  logic [HALF_W-1:0]         half_len,
    input  logic                      wr_en,
    input  logic                      wr_right,
    input  logic [CNT_W-1:0]          wr_idx,
    input  logic [NLINE-1:0]          din,
    input  logic                      frame_start,
    input  logic                      publish,
    input  logic                      dp_clear,
    output logic [2*NLINE*WORD_W-1:0] dac_data,
    output logic                      frame_valid
);
    import audio_rx_pkg::*;

    localparam int unsigned NCH = 2 * NLINE;
    localparam int unsigned BW  = $clog2(WORD_W);

    logic             in_half;
    logic [CNT_W-1:0] pos;

    // Position of the bit within a single-line frame.
    always_comb begin
        in_half = (wr_idx < CNT_W'(SL_HALF));
        pos     = CNT_W'({wr_right, wr_idx[5:0]});
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int unsigned   LINE = ch / 2;
        localparam logic          SIDE = 1'(ch % 2);
        localparam logic [CNT_W-1:0] LO = CNT_W'(ch * WORD_W);
        localparam logic [CNT_W-1:0] HI = CNT_W'((ch + 1) * WORD_W);

        logic [WORD_W-1:0] acc_q, acc_d, out_q;
        logic              hit;
        logic [BW-1:0]     bpos;
        logic [CNT_W-1:0]  off;
        logic              bit_v;

        // Pick whether this channel takes the current bit, and where.
        always_comb begin
            off = pos - LO;
            if (single) begin
                hit   = wr_en && in_half && (pos >= LO) && (pos < HI);
                bpos  = BW'(WORD_W - 1) - off[BW-1:0];
                bit_v = din[0];
            end else begin
                hit   = wr_en && (wr_right == SIDE) && (wr_idx < CNT_W'(WORD_W))
                        && (wr_idx < CNT_W'(half_len));
                bpos  = BW'(WORD_W - 1) - wr_idx[BW-1:0];
                bit_v = din[LINE];
            end
            acc_d = frame_start ? '0 : acc_q;
            if (hit)
                acc_d[bpos] = bit_v;
        end

        // Accumulator and published word for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n || dp_clear) begin
                acc_q <= '0;
                out_q <= '0;
            end else begin
                acc_q <= acc_d;
                if (publish)
                    out_q <= acc_q;
            end
        end

        assign dac_data[ch*WORD_W +: WORD_W] = out_q;
    end

    // One-cycle strobe alongside the published words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_valid <= 1'b0;
        else
            frame_valid <= publish && !dp_clear;
    end

endmodule

// File: rtl/audio_ser_rx.sv
// Multi-channel audio serial receiver top. Connects clock generation, input
// synchronization, frame tracking and channel unpacking. Assumes configuration
// inputs are changed only while rst_n is low.
module audio_ser_rx #(
    parameter int unsigned WORD_W  = 20,
    parameter int unsigned NLINE   = 3,
    parameter int unsigned CLK_DIV = 3,
    parameter int unsigned CNT_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                cfg_mode,
    input  logic [1:0]                cfg_ratio,
    input  logic                      cfg_edge,
    input  logic                      cfg_single,
    input  logic                      bclk_in,
    input  logic                      lrck_in,
    input  logic [NLINE-1:0]          sdata_in,
    output logic                      bclk_out,
    output logic                      lrck_out,
    output logic                      clk_oe,
    output logic [2*NLINE*WORD_W-1:0] dac_data,
    output logic                      frame_valid,
    output logic                      sync_err
);
    import audio_rx_pkg::*;

    logic              master;
    logic [HALF_W-1:0] half_len;
    logic              bclk_g, lrck_g;
    logic              bit_stb, bit_lr;
    logic [NLINE-1:0]  bit_d;
    logic              wr_en, wr_right, frame_start, publish, dp_clear;
    logic [CNT_W-1:0]  wr_idx;

    // Role and half-frame length from configuration.
    always_comb begin
        master   = (cfg_mode == MODE_MASTER);
        half_len = half_of(cfg_ratio, cfg_single);
        clk_oe   = master;
        bclk_out = master && bclk_g;
        lrck_out = master && lrck_g;
    end

    ars_clkgen #(.DIV(CLK_DIV), .HALF_W(HALF_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .en(master), .edge_sel(cfg_edge),
        .half_len(half_len), .bclk_o(bclk_g), .lrck_o(lrck_g)
    );

    ars_front #(.NLINE(NLINE)) u_front (
        .clk(clk), .rst_n(rst_n), .master(master), .edge_sel(cfg_edge),
        .bclk_pin(bclk_in), .lrck_pin(lrck_in), .sd_pin(sdata_in),
        .bclk_gen(bclk_g), .lrck_gen(lrck_g),
        .bit_stb(bit_stb), .bit_lr(bit_lr), .bit_d(bit_d)
    );

    ars_framer #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_lr(bit_lr),
        .half_len(half_len), .wr_en(wr_en), .wr_right(wr_right),
        .wr_idx(wr_idx), .frame_start(frame_start), .publish(publish),
        .dp_clear(dp_clear), .sync_err(sync_err)
    );

    ars_unpack #(.WORD_W(WORD_W), .NLINE(NLINE), .CNT_W(CNT_W),
                 .HALF_W(HALF_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .single(cfg_single), .half_len(half_len),
        .wr_en(wr_en), .wr_right(wr_right), .wr_idx(wr_idx), .din(bit_d),
        .frame_start(frame_start), .publish(publish), .dp_clear(dp_clear),
        .dac_data(dac_data), .frame_valid(frame_valid)
    );

endmodule

// Property checker for the receiver's outputs, bound to the top module.
module audio_ser_rx_chk #(
    parameter int unsigned DW = 120
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_mode,
    input logic          cfg_edge,
    input logic          bclk_out,
    input logic          lrck_out,
    input logic [DW-1:0] dac_data,
    input logic          frame_valid,
    input logic          sync_err
);
    // R7: the strobe lasts one cycle.
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R7: words move only with the strobe or a sync error.
    a_r7_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_valid && !sync_err) |-> $stable(dac_data));

    // R8: a sync error comes with cleared words and no strobe.
    a_r8_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> (dac_data == '0 && !frame_valid));

    // R10: generated frame clock changes only on the non-sampling edge.
    a_r10_lr_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b01 && !$stable(lrck_out)) |-> (bclk_out == cfg_edge));
endmodule

bind audio_ser_rx audio_ser_rx_chk #(.DW(2*NLINE*WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_edge(cfg_edge),
    .bclk_out(bclk_out), .lrck_out(lrck_out), .dac_data(dac_data),
    .frame_valid(frame_valid), .sync_err(sync_err)
);

// File: tb/audio_ser_rx_bench.sv
module audio_ser_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 3;     // clk cycles per bit-clock level (slave)
    localparam int CLK_DIV    = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   cfg_mode = 2'b00;
    logic [1:0]   cfg_ratio = 2'b00;
    logic         cfg_edge = 1'b0;
    logic         cfg_single = 1'b0;
    logic         bclk_in = 1'b0;
    logic         lrck_in = 1'b1;
    logic [2:0]   sdata_in = 3'b000;
    logic         bclk_out, lrck_out, clk_oe, frame_valid, sync_err;
    logic [119:0] dac_data;

    int n_tests = 0;
    int n_fail  = 0;
    int vcount, ecount, err_dirty;
    logic [119:0] first_cap, last_cap;
    bit done = 0;

    audio_ser_rx #(.CLK_DIV(CLK_DIV)) u_audio_ser_rx (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_ratio(cfg_ratio),
        .cfg_edge(cfg_edge), .cfg_single(cfg_single), .bclk_in(bclk_in),
        .lrck_in(lrck_in), .sdata_in(sdata_in), .bclk_out(bclk_out),
        .lrck_out(lrck_out), .clk_oe(clk_oe), .dac_data(dac_data),
        .frame_valid(frame_valid), .sync_err(sync_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && frame_valid) begin
            if (vcount == 0) first_cap = dac_data;
            last_cap = dac_data;
            vcount++;
        end
        if (rst_n && sync_err) begin
            ecount++;
            if (dac_data != '0 || frame_valid) err_dirty++;
        end
    end

    task automatic check(input string req, input logic [119:0] act, input logic [119:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] word(input int f, input int ch);
        return 20'(((f * 6 + ch) * 40503 + 32'h5A5A5) ^ (32'h80000 >> ch));
    endfunction

    function automatic logic [119:0] exp_frame(input int f, input int half);
        logic [119:0] v;
        logic [19:0]  m;
        m = (half < 20) ? ~((20'(1) << (20 - half)) - 20'(1)) : '1;
        for (int ch = 0; ch < 6; ch++) v[ch*20 +: 20] = word(f, ch) & m;
        return v;
    endfunction

    // Data for bit i of a half; unused positions carry ones (must be ignored).
    function automatic logic [2:0] line_bits(input int f, input bit right, input int i,
                                             input bit single);
        logic [2:0] d;
        int pos;
        d = 3'b111;
        if (single) begin
            pos = (right ? 64 : 0) + i;
            if (i < 64 && pos < 120) d[0] = word(f, pos / 20)[19 - (pos % 20)];
        end else begin
            for (int l = 0; l < 3; l++)
                if (i < 20) d[l] = word(f, 2*l + (right ? 1 : 0))[19 - i];
        end
        return d;
    endfunction

    task automatic bit_out(input logic lr, input logic [2:0] d);
        lrck_in  = lr;
        sdata_in = d;
        repeat (H) @(negedge clk);
        bclk_in = ~cfg_edge;
        repeat (H) @(negedge clk);
        bclk_in = cfg_edge;
    endtask

    task automatic send_frame(input int f, input int lb, input int rb, input bit single);
        for (int i = 0; i < lb; i++) bit_out(1'b0, line_bits(f, 1'b0, i, single));
        for (int i = 0; i < rb; i++) bit_out(1'b1, line_bits(f, 1'b1, i, single));
    endtask

    task automatic apply_cfg(input logic [1:0] mode, input logic [1:0] ratio,
                             input logic edge_s, input logic single);
        rst_n = 1'b0;
        @(negedge clk);
        cfg_mode = mode; cfg_ratio = ratio; cfg_edge = edge_s; cfg_single = single;
        bclk_in = edge_s; lrck_in = 1'b1; sdata_in = '0;
        repeat (4) @(negedge clk);
        vcount = 0; ecount = 0; err_dirty = 0; first_cap = '0; last_cap = '0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic close_run(input int half);
        for (int i = 0; i < half; i++) bit_out(1'b1, 3'b000);
    endtask

    task automatic run_normal(input logic [1:0] ratio, input logic edge_s,
                              input logic single, input int half);
        apply_cfg(2'b10, ratio, edge_s, single);   // 2'b10 = slave
        close_run(half);                           // preamble right half
        for (int f = 0; f < 3; f++) send_frame(f, half, half, single);
        bit_out(1'b0, 3'b000);
        repeat (8) @(negedge clk);
        check(single ? "R6 count" : "R7 count", 120'(vcount), 120'(2));
        check("R9 first published frame", first_cap, exp_frame(1, half));
        check(single ? "R6 words" : (edge_s ? "R4 R5 words" : "R2 R3 R5 words"),
              last_cap, exp_frame(2, half));
        check("R8 no error", 120'(ecount), 120'(0));
    endtask

    task automatic master_run(input int nbits);
        logic prev_lr;
        int   idx;
        int   last_half;
        prev_lr = 1'b1; idx = 0; last_half = 0;
        for (int n = 0; n < nbits; n++) begin
            do @(bclk_out); while (bclk_out !== cfg_edge);
            #1;
            if (lrck_out != prev_lr) begin
                last_half = idx + 1;
                idx = 0;
            end else begin
                idx++;
            end
            prev_lr  = lrck_out;
            sdata_in = line_bits(5, lrck_out, idx, 1'b0);
        end
        check("R10 half length", 120'(last_half), 120'(32));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        time t0;
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 data in reset", dac_data, '0);
        check("R1 strobes in reset", 120'({frame_valid, sync_err}), 120'(0));
        apply_cfg(2'b00, 2'b10, 1'b0, 1'b0);
        check("R1 data after reset", dac_data, '0);
        check("R1 clk_oe slave", 120'({clk_oe, bclk_out, lrck_out}), 120'(0));

        // R3/R4/R5/R2: every ratio on both edges, multi-line
        for (int r = 0; r < 4; r++)
            for (int e = 0; e < 2; e++)
                run_normal(2'(r), 1'(e), 1'b0, (r == 0) ? 16 : (r == 1) ? 24 : (r == 2) ? 32 : 64);

        // R6: single line, ratio select ignored
        run_normal(2'b00, 1'b1, 1'b1, 64);
        run_normal(2'b01, 1'b0, 1'b1, 64);

        // R8/R9: short left half in frame 2
        apply_cfg(2'b00, 2'b10, 1'b0, 1'b0);
        close_run(32);
        send_frame(0, 32, 32, 0); send_frame(1, 32, 32, 0);
        send_frame(2, 31, 32, 0);
        send_frame(3, 32, 32, 0); send_frame(4, 32, 32, 0); send_frame(5, 32, 32, 0);
        bit_out(1'b0, 3'b000);
        repeat (8) @(negedge clk);
        check("R8 short error count", 120'(ecount), 120'(1));
        check("R8 cleared on error", 120'(err_dirty), 120'(0));
        check("R9 relock count short", 120'(vcount), 120'(3));
        check("R9 before error", first_cap, exp_frame(1, 32));
        check("R9 after relock", last_cap, exp_frame(5, 32));

        // R8/R9: long right half in frame 2
        apply_cfg(2'b00, 2'b10, 1'b1, 1'b0);
        close_run(32);
        send_frame(0, 32, 32, 0); send_frame(1, 32, 32, 0);
        send_frame(2, 32, 33, 0);
        send_frame(3, 32, 32, 0); send_frame(4, 32, 32, 0);
        bit_out(1'b0, 3'b000);
        repeat (8) @(negedge clk);
        check("R8 long error count", 120'(ecount), 120'(1));
        check("R8 cleared on long error", 120'(err_dirty), 120'(0));
        check("R9 relock count long", 120'(vcount), 120'(2));
        check("R9 after long relock", last_cap, exp_frame(4, 32));

        // R10: master mode, 64-bit frame
        apply_cfg(2'b01, 2'b10, 1'b0, 1'b0);
        check("R10 clk_oe master", 120'(clk_oe), 120'(1));
        @(posedge bclk_out); t0 = $time;
        @(posedge bclk_out);
        check("R10 bclk period", 120'($time - t0), 120'(2 * CLK_DIV * CLK_PERIOD));
        master_run(64 * 5);
        repeat (2 * CLK_DIV * 4) @(negedge clk);
        check("R10 master frames", 120'(vcount >= 2), 120'(1));
        check("R10 master words", last_cap, exp_frame(5, 32));
        check("R10 master no error", 120'(ecount), 120'(0));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule